// File: doc/BRIEF.md
# Halt Instruction Control Unit

This unit sits in a simple processor front end and handles the one-byte stop instruction. When the decoder presents that opcode, the unit checks privilege against the current operating mode. The result is one of three outcomes. It can signal a general-protection fault with a zero error code. It can hand the instruction to a supervising environment through an intercept strobe. Or it can park the core: fetch is held stalled and the address of the following instruction is kept as the return pointer.

A parked core resumes when one of three events arrives: a non-maskable interrupt, a maskable interrupt while interrupts are enabled, or reset. On an interrupt wake the unit emits a one-cycle strobe that carries the cause. The interrupt logic uses that strobe and the saved pointer to vector the core. Interrupt vectoring and the rest of the decoder live elsewhere. The instruction changes no status flags, so the unit has no flag outputs.

Top module: `core_park_ctrl`

## Requirements
- R1: An instruction is accepted only when `op_valid_i` is high and `opcode_i` equals 0xF4. Any other opcode produces no fault, no intercept and no halt.
- R2: In protected mode (`mode_i`=2'b01) or virtual-8086 mode (`mode_i`=2'b10), an accepted instruction with `cpl_i`≠0 pulses `gp_fault_o` on the next cycle with `gp_code_o`=0, and the core does not halt.
- R3: In real-address mode (`mode_i`=2'b00), no privilege check applies. With any `cpl_i` and the intercept flag low, the core halts and no fault is raised.
- R4: When `icpt_env_i` is high and the privilege check passes, an accepted instruction pulses `intercept_o` on the next cycle and the core does not halt. A failing privilege check takes precedence and raises the fault instead.
- R5: `halted_o` and `fetch_stall_o` rise on the cycle after a halt is accepted. While halted, further valid 0xF4 strobes produce no fault or intercept.
- R6: While halted, a maskable request (`irq_i`) with `int_en_i` low does not wake the core.
- R7: While halted, `irq_i` with `int_en_i` high clears `halted_o` on the next cycle. In that same cycle `wake_o` pulses with `wake_cause_o`=2'b01.
- R8: While halted, `nmi_i` wakes the core whatever the value of `int_en_i`, with `wake_cause_o`=2'b10. When both requests are present in one cycle, the NMI cause is reported.
- R9: `ret_ptr_o` takes the value of `next_ip_i` at halt acceptance and holds it through the halt and after the wake.
- R10: Asserting `rst_ni` low clears `halted_o`, `fetch_stall_o` and `ret_ptr_o`.
- R11: `gp_fault_o`, `intercept_o` and `wake_o` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also a wake source |
| opcode_i | input | 8 | Fetched opcode byte |
| op_valid_i | input | 1 | Decode-valid strobe |
| mode_i | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual-8086 |
| cpl_i | input | 2 | Current privilege level |
| icpt_env_i | input | 1 | Supervising environment intercepts the instruction |
| int_en_i | input | 1 | Maskable interrupts enabled |
| irq_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| next_ip_i | input | AW | Address of the instruction after the current one |
| halted_o | output | 1 | Core is parked |
| fetch_stall_o | output | 1 | Hold instruction fetch |
| gp_fault_o | output | 1 | General-protection fault pulse |
| gp_code_o | output | EW | Fault error code (always zero) |
| intercept_o | output | 1 | Intercept pulse to the supervising environment |
| ret_ptr_o | output | AW | Saved return pointer |
| wake_o | output | 1 | Resume pulse |
| wake_cause_o | output | 2 | Cause of resume: 01 interrupt, 10 NMI |

## Verification
The pulse assertions assume the decoder raises `op_valid_i` for exactly one cycle per instruction. They also assume it holds the mode, privilege and intercept flag steady during that cycle. Every bench task therefore drives the strobe for a single cycle, with a gap after it. The stability check on the return pointer assumes `next_ip_i` matters only at acceptance. To confirm that, the bench changes `next_ip_i` while the core is parked and checks that the saved value does not move.

// File: rtl/park_pkg.sv
package park_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10
  } cpu_mode_e;

  typedef enum logic [1:0] {
    WAKE_NONE = 2'b00,
    WAKE_IRQ  = 2'b01,
    WAKE_NMI  = 2'b10
  } wake_cause_e;

  typedef struct packed {
    logic fault;
    logic trap;
    logic park;
  } verdict_t;
endpackage

// File: rtl/park_check.sv
module park_check
  import park_pkg::*;
#(
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC = 8'hF4,
  parameter int unsigned PL_W = 2
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic             env_i,
  input  logic             busy_i,
  output verdict_t         verdict_o
);
  logic hit, priv_bad;

  assign hit      = valid_i && (opcode_i == OPC) && !busy_i;
  // only real-address mode skips the privilege check
  assign priv_bad = (mode_i != MODE_REAL) && (cpl_i != '0);

  always_comb begin
    verdict_o       = '0;
    verdict_o.fault = hit && priv_bad;
    verdict_o.trap  = hit && !priv_bad && env_i;
    verdict_o.park  = hit && !priv_bad && !env_i;
  end
endmodule

// File: rtl/park_wake.sv
module park_wake
  import park_pkg::*;
#(
  parameter bit NMI_FIRST = 1'b1
) (
  input  logic        halted_i,
  input  logic        irq_i,
  input  logic        int_en_i,
  input  logic        nmi_i,
  output logic        wake_o,
  output wake_cause_e cause_o
);
  logic irq_ok;
  assign irq_ok = irq_i && int_en_i;
  assign wake_o = halted_i && (nmi_i || irq_ok);

  generate
    if (NMI_FIRST) begin : g_nmi_first
      always_comb begin
        cause_o = WAKE_NONE;
        if (halted_i) begin
          if (nmi_i)       cause_o = WAKE_NMI;
          else if (irq_ok) cause_o = WAKE_IRQ;
        end
      end
    end else begin : g_irq_first
      always_comb begin
        cause_o = WAKE_NONE;
        if (halted_i) begin
          if (irq_ok)     cause_o = WAKE_IRQ;
          else if (nmi_i) cause_o = WAKE_NMI;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/park_state.sv
module park_state
  import park_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  verdict_t      verdict_i,
  input  logic          wake_i,
  input  wake_cause_e   cause_i,
  input  logic [AW-1:0] next_ip_i,
  input  logic          irq_i,
  input  logic          int_en_i,
  input  logic          nmi_i,
  output logic          halted_o,
  output logic [AW-1:0] ret_ptr_o,
  output logic          fault_o,
  output logic          trap_o,
  output logic          wake_o,
  output wake_cause_e   cause_o
);
  logic halted_q;
  logic [AW-1:0] ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      ret_q    <= '0;
      fault_o  <= 1'b0;
      trap_o   <= 1'b0;
      wake_o   <= 1'b0;
      cause_o  <= WAKE_NONE;
    end else begin
      fault_o <= verdict_i.fault;
      trap_o  <= verdict_i.trap;
      wake_o  <= wake_i;
      cause_o <= wake_i ? cause_i : WAKE_NONE;
      if (verdict_i.park) begin
        halted_q <= 1'b1;
        ret_q    <= next_ip_i;
      end else if (wake_i) begin
        halted_q <= 1'b0;
      end
    end
  end

  assign halted_o  = halted_q;
  assign ret_ptr_o = ret_q;

  a_r6_masked_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && irq_i && !int_en_i && !nmi_i) |=> halted_q);
  a_r8_nmi_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && nmi_i) |=> (!halted_q && wake_o && cause_o == WAKE_NMI));
  a_r7_irq_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && irq_i && int_en_i && !nmi_i) |=> (!halted_q && cause_o == WAKE_IRQ));
  a_r9_ptr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> $stable(ret_q));
  a_r5_no_fault_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> !(fault_o || trap_o));
endmodule

// File: rtl/core_park_ctrl.sv
module core_park_ctrl
  import park_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned EW    = 16,
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC = 8'hF4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             op_valid_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       cpl_i,
  input  logic             icpt_env_i,
  input  logic             int_en_i,
  input  logic             irq_i,
  input  logic             nmi_i,
  input  logic [AW-1:0]    next_ip_i,
  output logic             halted_o,
  output logic             fetch_stall_o,
  output logic             gp_fault_o,
  output logic [EW-1:0]    gp_code_o,
  output logic             intercept_o,
  output logic [AW-1:0]    ret_ptr_o,
  output logic             wake_o,
  output logic [1:0]       wake_cause_o
);
  localparam logic [EW-1:0] FAULT_CODE = '0;

  verdict_t    verdict;
  logic        wake_req;
  wake_cause_e wake_sel, cause_q;
  logic        halted;

  park_check #(.OPC_W(OPC_W), .OPC(OPC), .PL_W(2)) u_check (
    .opcode_i (opcode_i),
    .valid_i  (op_valid_i),
    .mode_i   (mode_i),
    .cpl_i    (cpl_i),
    .env_i    (icpt_env_i),
    .busy_i   (halted),
    .verdict_o(verdict)
  );

  park_wake #(.NMI_FIRST(1'b1)) u_wake (
    .halted_i(halted),
    .irq_i   (irq_i),
    .int_en_i(int_en_i),
    .nmi_i   (nmi_i),
    .wake_o  (wake_req),
    .cause_o (wake_sel)
  );

  park_state #(.AW(AW)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .verdict_i(verdict),
    .wake_i   (wake_req),
    .cause_i  (wake_sel),
    .next_ip_i(next_ip_i),
    .irq_i    (irq_i),
    .int_en_i (int_en_i),
    .nmi_i    (nmi_i),
    .halted_o (halted),
    .ret_ptr_o(ret_ptr_o),
    .fault_o  (gp_fault_o),
    .trap_o   (intercept_o),
    .wake_o   (wake_o),
    .cause_o  (cause_q)
  );

  assign halted_o      = halted;
  assign fetch_stall_o = halted;
  assign gp_code_o     = FAULT_CODE;
  assign wake_cause_o  = cause_q;

  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gp_fault_o, intercept_o, wake_o}));
  a_r11_fault_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp_fault_o |=> !gp_fault_o);
  a_r11_trap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intercept_o |=> !intercept_o);
  a_r2_fault_not_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gp_fault_o) |-> !$rose(halted_o));
endmodule

// File: tb/sim_core_park_ctrl.sv
module sim_core_park_ctrl;
  localparam int AW = 32;
  localparam int EW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] opcode = '0;
  logic op_valid = 1'b0, icpt_env = 1'b0, int_en = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [1:0] mode = 2'b00, cpl = 2'b00;
  logic [AW-1:0] next_ip = '0;
  logic halted, stall, gp_fault, intercept, wake;
  logic [EW-1:0] gp_code;
  logic [AW-1:0] ret_ptr;
  logic [1:0] cause;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  core_park_ctrl #(.AW(AW), .EW(EW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .opcode_i(opcode), .op_valid_i(op_valid),
    .mode_i(mode), .cpl_i(cpl), .icpt_env_i(icpt_env), .int_en_i(int_en),
    .irq_i(irq), .nmi_i(nmi), .next_ip_i(next_ip), .halted_o(halted),
    .fetch_stall_o(stall), .gp_fault_o(gp_fault), .gp_code_o(gp_code),
    .intercept_o(intercept), .ret_ptr_o(ret_ptr), .wake_o(wake),
    .wake_cause_o(cause)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle decode strobe, returns just after the capturing edge
  task automatic issue(logic [7:0] op, logic [1:0] m, logic [1:0] pl, logic env, logic [AW-1:0] ip);
    @(negedge clk);
    opcode = op; mode = m; cpl = pl; icpt_env = env; next_ip = ip; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; opcode = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; irq = 0; nmi = 0; int_en = 0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    chk("R10 reset halted", halted, 0);
    chk("R10 reset stall", stall, 0);
    chk("R10 reset ptr", ret_ptr, 0);
    chk("R11 reset strobes", {gp_fault, intercept, wake}, 0);
  endtask

  task automatic t_other_opcode();
    issue(8'h90, 2'b00, 2'b00, 1'b0, 32'h100);
    chk("R1 other opcode no halt", halted, 0);
    chk("R1 other opcode no strobe", {gp_fault, intercept}, 0);
  endtask

  task automatic t_priv_fault(logic [1:0] m);
    issue(8'hF4, m, 2'b11, 1'b1, 32'h200);
    chk("R2 fault pulse", gp_fault, 1);
    chk("R2 fault code", gp_code, 0);
    chk("R4 fault wins over intercept", intercept, 0);
    chk("R2 no halt", halted, 0);
    @(negedge clk);
    chk("R11 fault single cycle", gp_fault, 0);
  endtask

  task automatic t_intercept();
    issue(8'hF4, 2'b01, 2'b00, 1'b1, 32'h300);
    chk("R4 intercept pulse", intercept, 1);
    chk("R4 no halt on intercept", halted, 0);
    chk("R4 no fault on intercept", gp_fault, 0);
    @(negedge clk);
    chk("R11 intercept single cycle", intercept, 0);
  endtask

  task automatic t_real_halt_irq();
    issue(8'hF4, 2'b00, 2'b11, 1'b0, 32'h1234_5678);
    chk("R3 real mode halts", halted, 1);
    chk("R5 stall asserted", stall, 1);
    chk("R3 no fault in real mode", gp_fault, 0);
    chk("R9 ptr saved", ret_ptr, 32'h1234_5678);
    issue(8'hF4, 2'b01, 2'b11, 1'b1, 32'hDEAD);
    chk("R5 ignored while halted", {gp_fault, intercept}, 0);
    chk("R9 ptr unchanged by next_ip", ret_ptr, 32'h1234_5678);
    irq = 1; int_en = 0;
    repeat (3) @(negedge clk);
    chk("R6 masked irq no wake", halted, 1);
    chk("R6 masked no wake strobe", wake, 0);
    int_en = 1;
    @(negedge clk);
    irq = 0;
    chk("R7 irq wakes", halted, 0);
    chk("R7 wake strobe", wake, 1);
    chk("R7 wake cause irq", cause, 2'b01);
    chk("R9 ptr after wake", ret_ptr, 32'h1234_5678);
    @(negedge clk);
    chk("R11 wake single cycle", wake, 0);
  endtask

  task automatic t_prot_halt_nmi();
    issue(8'hF4, 2'b10, 2'b00, 1'b0, 32'hA0);
    chk("R5 v86 cpl0 halts", halted, 1);
    int_en = 0; nmi = 1; irq = 1;
    @(negedge clk);
    nmi = 0; irq = 0;
    chk("R8 nmi wakes masked", halted, 0);
    chk("R8 nmi cause", cause, 2'b10);
    issue(8'hF4, 2'b01, 2'b00, 1'b0, 32'hB0);
    int_en = 1; nmi = 1; irq = 1;
    @(negedge clk);
    nmi = 0; irq = 0;
    chk("R8 nmi priority over irq", cause, 2'b10);
    chk("R9 ptr second halt", ret_ptr, 32'hB0);
  endtask

  task automatic t_reset_wake();
    issue(8'hF4, 2'b00, 2'b00, 1'b0, 32'hC0);
    chk("R10 pre-reset halted", halted, 1);
    #2 rst_ni = 1'b0;
    #1;
    chk("R10 reset clears halted", halted, 0);
    chk("R10 reset clears stall", stall, 0);
    chk("R10 reset clears ptr", ret_ptr, 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_other_opcode();
    t_priv_fault(2'b01);
    t_priv_fault(2'b10);
    t_intercept();
    t_real_halt_irq();
    do_reset();
    t_prot_halt_nmi();
    t_reset_wake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule